// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two 16-bit two's complement integers without a hardware multiplier array. It uses one adder and a handful of shift registers. A one-cycle start strobe captures the multiplicand and the multiplier. The block then spends one clock per multiplier bit. In each step it inspects the lowest remaining multiplier bit and may fold the sign-extended multiplicand into a high accumulator. It then moves the whole high/low register pair one place to the right. The step for the multiplier's sign bit subtracts rather than adds, so negative multipliers need no correction afterwards.

The full 32-bit product is presented on one port. A second port presents the fractional (Q15) view, which is the product moved left by one with only its upper 16 bits kept. A caller pulses start, waits for the one-cycle done pulse and reads either port. Both stay valid until the next accepted start.

Top module: `smul_seq`

## Requirements
- R1: After synchronous reset, busy and done are 0, product is 0 and q15_out is 0.
- R2: When start is 1 on a rising edge while busy is 0, the block captures mcand_in and mplier_in and busy is 1 from that edge on.
- R3: done is 1 for exactly one cycle. It rises on the 16th rising edge after the edge that accepted start, and busy falls on that same edge.
- R4: When done is 1, product equals the signed 32-bit product of the captured operands, for every combination of operand signs.
- R5: The operand pair -32768 × -32768 yields product 0x4000_0000. Operand pairs that include -32768 together with 32767 or -1 also give the exact product.
- R6: A start pulse while busy is 1 has no effect: the running operation keeps its operands and its done timing.
- R7: q15_out equals bits 30 down to 15 of product.
- R8: Once done has pulsed, product and q15_out hold their values until the next accepted start, whatever the operand inputs do.
- R9: A start presented in the cycle where done is 1 is accepted, and the new operation completes with its own correct product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication (ignored while busy) |
| mcand_in | input | 16 | Signed multiplicand |
| mplier_in | input | 16 | Signed multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 32 | Signed product |
| q15_out | output | 16 | Product bits 30..15 (Q15 result) |

## Verification
The assertions watch the handshake on every cycle: busy and done are never high together, done lasts a single cycle, and done arrives only after exactly sixteen busy cycles. Each done is checked against a reference product built from the operands captured at acceptance. The assertions also check that product stays put while idle. The bench scenarios cover what a property cannot reach by itself. These include the reset values, a grid of signed corner values including the most negative pair, a pseudo-random sweep, a start pulse fired in the middle of an operation, operand changes after completion and a restart in the done cycle.

// File: rtl/smul_pkg.sv
package smul_pkg;

    localparam int unsigned SMUL_DEF_W = 16;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } smul_state_e;

    // control handed from the sequencer to the datapath
    typedef struct packed {
        logic load;   // capture operands, clear accumulator
        logic step;   // perform one add/shift iteration
        logic last;   // current iteration handles the multiplier sign bit
    } smul_ctl_t;

endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
    import smul_pkg::*;
#(
    parameter int unsigned W = SMUL_DEF_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output smul_ctl_t ctl,
    output logic      busy,
    output logic      done
);

    localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(W - 1);

    smul_state_e      state_q;
    logic [CNT_W-1:0] iter_q;
    logic             done_q;
    logic             accept;

    assign accept = (state_q == ST_IDLE) && start;

    always_comb begin
        ctl.load = accept;
        ctl.step = (state_q == ST_RUN);
        ctl.last = (state_q == ST_RUN) && (iter_q == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_RUN;
                        iter_q  <= '0;
                    end
                end
                ST_RUN: begin
                    if (iter_q == LAST_IDX) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        iter_q <= iter_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q == ST_RUN);
    assign done = done_q;

endmodule

// File: rtl/smul_dp.sv
module smul_dp
    import smul_pkg::*;
#(
    parameter int unsigned W = SMUL_DEF_W
) (
    input  logic           clk,
    input  logic           rst,
    input  smul_ctl_t      ctl,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] full_out
);

    localparam int unsigned AW = W + 1;   // guard bit keeps the sign through add/sub

    logic [AW-1:0] acc_q;
    logic [W-1:0]  lo_q;
    logic [W-1:0]  mq_q;
    logic [W-1:0]  md_q;

    logic [AW-1:0] addend;
    logic [AW-1:0] sum;

    always_comb begin
        addend = {md_q[W-1], md_q};
        if (!mq_q[0])
            sum = acc_q;
        else if (ctl.last)
            sum = acc_q - addend;
        else
            sum = acc_q + addend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            lo_q  <= '0;
            mq_q  <= '0;
            md_q  <= '0;
        end else if (ctl.load) begin
            acc_q <= '0;
            lo_q  <= '0;
            mq_q  <= mplier_in;
            md_q  <= mcand_in;
        end else if (ctl.step) begin
            acc_q <= {sum[AW-1], sum[AW-1:1]};
            lo_q  <= {sum[0], lo_q[W-1:1]};
            mq_q  <= {1'b0, mq_q[W-1:1]};
        end
    end

    assign full_out = {acc_q[W-1:0], lo_q};

endmodule

// File: rtl/smul_fmt.sv
module smul_fmt
    import smul_pkg::*;
#(
    parameter int unsigned W = SMUL_DEF_W
) (
    input  logic [2*W-1:0] full_in,
    output logic [2*W-1:0] product,
    output logic [W-1:0]   frac_out
);

    // fractional view: drop the duplicated sign bit, keep the upper word
    generate
        if (W > 1) begin : g_frac
            assign frac_out = full_in[2*W-2:W-1];
        end else begin : g_frac_min
            assign frac_out = full_in[W-1:0];
        end
    endgenerate

    assign product = full_in;

endmodule

// File: rtl/smul_seq.sv
module smul_seq
    import smul_pkg::*;
#(
    parameter int unsigned W = SMUL_DEF_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product,
    output logic [W-1:0]   q15_out
);

    smul_ctl_t      ctl;
    logic [2*W-1:0] full;

    smul_ctrl #(.W(W)) ctrl_i (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl),
        .busy  (busy),
        .done  (done)
    );

    smul_dp #(.W(W)) dp_i (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mcand_in  (mcand_in),
        .mplier_in (mplier_in),
        .full_out  (full)
    );

    smul_fmt #(.W(W)) fmt_i (
        .full_in  (full),
        .product  (product),
        .frac_out (q15_out)
    );

endmodule

// File: rtl/smul_seq_chk.sv
module smul_seq_chk #(
    parameter int unsigned W = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [W-1:0]   mcand_in,
    input logic [W-1:0]   mplier_in,
    input logic           busy,
    input logic           done,
    input logic [2*W-1:0] product
);

    logic [W-1:0]   a_q, b_q;
    logic [31:0]    run_cnt;
    logic [2*W-1:0] ref_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q     <= '0;
            b_q     <= '0;
            run_cnt <= '0;
        end else begin
            if (start && !busy) begin
                a_q <= mcand_in;
                b_q <= mplier_in;
            end
            if (busy) run_cnt <= run_cnt + 1;
            else      run_cnt <= '0;
        end
    end

    assign ref_p = $signed({{W{a_q[W-1]}}, a_q}) * $signed({{W{b_q[W-1]}}, b_q});

    // R3
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == 32'(W)));

    // R2
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R4
    product_ref_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (product == ref_p));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));

endmodule

bind smul_seq smul_seq_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mcand_in  (mcand_in),
    .mplier_in (mplier_in),
    .busy      (busy),
    .done      (done),
    .product   (product)
);

// File: tb/smul_seq_tb_top.sv
`timescale 1ns/1ps
module smul_seq_tb_top;

    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [W-1:0]   mcand_in = '0;
    logic [W-1:0]   mplier_in = '0;
    logic           busy, done;
    logic [2*W-1:0] product;
    logic [W-1:0]   q15_out;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    smul_seq #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .start(start),
        .mcand_in(mcand_in), .mplier_in(mplier_in),
        .busy(busy), .done(done), .product(product), .q15_out(q15_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        longint pa, pb, pr;
        pa = longint'($signed(a));
        pb = longint'($signed(b));
        pr = pa * pb;
        return pr[31:0];
    endfunction

    // wait for done after the accept edge; returns edges counted
    task automatic wait_done(output int edges);
        edges = 0;
        while (!done && edges < 40) begin
            @(posedge clk); @(negedge clk);
            edges++;
        end
    endtask

    task automatic check_result(input logic [W-1:0] a, input logic [W-1:0] b,
                                input int edges, input string req);
        logic [31:0] e;
        e = ref_mul(a, b);
        chk(edges == 16, "R3", "latency", 64'(edges), 64'd16);
        chk(busy == 1'b0, "R3", "busy at done", 64'(busy), 64'd0);
        chk(product == e, req, "product", 64'(product), 64'(e));
        chk(q15_out == e[30:15], "R7", "q15_out", 64'(q15_out), 64'(e[30:15]));
    endtask

    task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        int edges;
        mcand_in = a; mplier_in = b; start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", 64'(busy), 64'd1);
        wait_done(edges);
        check_result(a, b, edges, req);
        @(posedge clk); @(negedge clk);
        chk(done == 1'b0, "R3", "done width", 64'(done), 64'd0);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1", "busy", 64'(busy), 64'd0);
        chk(done == 1'b0, "R1", "done", 64'(done), 64'd0);
        chk(product == '0, "R1", "product", 64'(product), 64'd0);
        chk(q15_out == '0, "R1", "q15_out", 64'(q15_out), 64'd0);
    endtask

    task automatic t_signs();
        run_mul(16'd123, 16'd45, "R4");
        run_mul(-16'sd123, 16'd45, "R4");
        run_mul(16'd123, -16'sd45, "R4");
        run_mul(-16'sd123, -16'sd45, "R4");
        run_mul(16'd0, -16'sd1, "R4");
    endtask

    task automatic t_corners();
        logic [W-1:0] vals [10];
        vals = '{16'h8000, 16'h7FFF, 16'hFFFF, 16'h0000, 16'h0001,
                 16'h8001, 16'h4000, 16'hC000, 16'h5555, 16'hAAAA};
        run_mul(16'h8000, 16'h8000, "R5");
        chk(product == 32'h4000_0000, "R5", "min*min", 64'(product), 64'h4000_0000);
        for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++)
                run_mul(vals[i], vals[j], "R5");
    endtask

    task automatic t_random();
        logic [31:0] lfsr = 32'hACE1_2468;
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            run_mul(lfsr[15:0], lfsr[31:16], "R4");
        end
    endtask

    task automatic t_ignore_start();
        int edges;
        mcand_in = 16'h1234; mplier_in = 16'hF00D; start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 5; k++) begin @(posedge clk); @(negedge clk); end
        mcand_in = 16'h7777; mplier_in = 16'h0003; start = 1'b1;   // R6: must be ignored
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R6", "still busy", 64'(busy), 64'd1);
        edges = 6;
        while (!done && edges < 40) begin
            @(posedge clk); @(negedge clk);
            edges++;
        end
        chk(edges == 16, "R6", "latency kept", 64'(edges), 64'd16);
        chk(product == ref_mul(16'h1234, 16'hF00D), "R6", "product kept",
            64'(product), 64'(ref_mul(16'h1234, 16'hF00D)));
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_hold();
        logic [31:0] e;
        run_mul(16'hFED3, 16'h0321, "R4");
        e = ref_mul(16'hFED3, 16'h0321);
        mcand_in = 16'h1111; mplier_in = 16'h2222;
        for (int k = 0; k < 6; k++) begin @(posedge clk); @(negedge clk); end
        chk(product == e, "R8", "product held", 64'(product), 64'(e));
        chk(q15_out == e[30:15], "R8", "q15 held", 64'(q15_out), 64'(e[30:15]));
        chk(busy == 1'b0, "R8", "no restart", 64'(busy), 64'd0);
    endtask

    task automatic t_back2back();
        int edges;
        mcand_in = 16'h0F0F; mplier_in = 16'h8003; start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        wait_done(edges);
        check_result(16'h0F0F, 16'h8003, edges, "R4");
        mcand_in = 16'hB00B; mplier_in = 16'h7FF1; start = 1'b1;   // in the done cycle
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9", "restart accepted", 64'(busy), 64'd1);
        wait_done(edges);
        check_result(16'hB00B, 16'h7FF1, edges, "R9");
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_signs();
        t_corners();
        t_random();
        t_ignore_start();
        t_hold();
        t_back2back();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule